// File: doc/BRIEF.md
# Interrupt Trigger Conditioner

This block turns 64 raw peripheral interrupt inputs into clean active-high request lines for a downstream interrupt router. Each line can be treated as a level, either active-high or active-low, or as an edge, either rising or falling. The lines are split into two banks of 32. Each bank has its own set of registers on a simple memory-mapped port made of a byte address, write data, a write strobe and combinational read data. The inputs are assumed to be synchronised to `clk` before they reach the block.

Each line has two configuration bits, one named rise and one named fall, and the pair picks the line's mode:

| rise | fall | Mode |
|------|------|------|
| 0 | 0 | Active-high level |
| 1 | 0 | Rising edge |
| 0 | 1 | Falling edge |
| 1 | 1 | Active-low level |

Software changes each configuration bit through separate write-one-to-set and write-one-to-clear addresses, so no read-modify-write is needed. In the edge modes a detected edge is held in a sticky bit. Software acknowledges it by writing ones to the raw-status address of the bank.

Each bank uses eight word registers. Bank 0 (lines 0 to 31) starts at byte address 0x00 and bank 1 (lines 32 to 63) at 0x20. The registers inside a bank are:

| Offset | Access | Register |
|--------|--------|----------|
| 0x00 | read | Conditioned output (status) |
| 0x04 | read / write ones | Raw view; a write acknowledges edge events |
| 0x08 | read | Rise bits |
| 0x0C | read | Fall bits |
| 0x10 | write | Set rise bits |
| 0x14 | write | Clear rise bits |
| 0x18 | write | Set fall bits |
| 0x1C | write | Clear fall bits |

Top module: `irq_trigger_cond`

## Requirements
- R1: After reset every rise bit, fall bit and sticky edge bit is 0, so every line starts in active-high level mode.
- R2: A write to set-rise (0x10), clear-rise (0x14), set-fall (0x18) or clear-fall (0x1C) changes only the configuration bits whose write-data bit is 1. Rise bits read back at 0x08 and fall bits at 0x0C, and bits written as 0 keep their value.
- R3: Address bit 5 selects the bank: 0 for lines 0–31, 1 for lines 32–63. Bits 4:2 select the register, and data bit i maps to line (32·bank + i). An access with address bits 1:0 not equal to 00 writes nothing and reads 0.
- R4: With rise=0 and fall=0, the line's output equals its input in the same cycle, with no latching.
- R5: With rise=1 and fall=1, the line's output is the inverse of its input in the same cycle.
- R6: With rise=1 and fall=0, a 0→1 input transition sets the sticky bit at the next clock edge. The output then stays 1 until the bit is acknowledged, even after the input falls.
- R7: With rise=0 and fall=1, a 1→0 input transition sets the sticky bit in the same way, and the output stays 1 until the bit is acknowledged.
- R8: Writing to raw status (0x04) clears the sticky bits of edge-mode lines whose data bit is 1. Bits written as 0, and the other bank, are unchanged.
- R9: If an edge arrives in the same cycle as an acknowledge of that line, the sticky bit stays set.
- R10: A write to raw status has no effect on level-mode lines; their outputs keep following their inputs.
- R11: Status (0x00) reads the bank's current conditioned outputs. Raw status (0x04) reads the sticky bit for edge-mode lines and the raw input for level-mode lines.
- R12: When a line goes from an edge mode to a level mode, its sticky bit is discarded. Returning to an edge mode with no new edge gives an output of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 6 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_in | input | 64 | Raw interrupt inputs, already synchronised |
| irq_out | output | 64 | Conditioned active-high request lines |

## Verification
The bench puts all 64 lines through each of the four modes in turn. It drives a series of vector patterns and computes the expected sticky state arithmetically from each pair of consecutive patterns.

- **Ack and edge in the same cycle.** An acknowledge lands in the same cycle as a new edge on one line, while a second line in the same write is acknowledged cleanly. A design that lets the acknowledge win would lose the first interrupt.
- **Partial acknowledge.** Part of each bank is acknowledged. A design that decodes the bank or the mask wrongly would clear sticky bits that were never acknowledged.
- **Ack on level lines.** Acknowledge writes go to lines in level mode. A design that latches level lines would show a stuck request after the input drops.
- **Mode round trip.** A line goes from edge mode to level mode and back. A design that keeps the stale sticky bit would raise an interrupt that never happened.

// File: rtl/trig_cond_pkg.sv
// Package: shared constants and types for the interrupt trigger conditioner.
// Assumes byte addressing with 32-bit registers and eight registers per bank.
package trig_cond_pkg;

    // Register select taken from address bits [4:2]; the offsets are software-visible.
    typedef enum logic [2:0] {
        SEL_STATUS   = 3'd0,
        SEL_RAW      = 3'd1,
        SEL_RISE_RD  = 3'd2,
        SEL_FALL_RD  = 3'd3,
        SEL_RISE_SET = 3'd4,
        SEL_RISE_CLR = 3'd5,
        SEL_FALL_SET = 3'd6,
        SEL_FALL_CLR = 3'd7
    } reg_sel_e;

    // Per-bank write strobes produced by the decoder.
    typedef struct packed {
        logic rise_set;
        logic rise_clr;
        logic fall_set;
        logic fall_clr;
        logic ack;
    } bank_wr_t;

    // Address bits that select the register inside a bank.
    localparam int SEL_LSB = 2;
    localparam int BANK_LSB = 5;

endpackage

// File: rtl/trig_reg_decode.sv
// Module: trig_reg_decode
// Turns a register access into per-bank write strobes and a read select.
// Assumes a single-cycle write strobe. Misaligned accesses (addr[1:0] != 0)
// produce no strobe and mark the read as invalid.
module trig_reg_decode
    import trig_cond_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 6,
    localparam int BIDX_W   = ADDR_W - BANK_LSB
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr,
    output bank_wr_t [NUM_BANKS-1:0]   strb,
    output logic [BIDX_W-1:0]          rd_bank,
    output reg_sel_e                   rd_sel,
    output logic                       rd_ok
);

    logic     aligned;
    reg_sel_e sel;

    // Split the address into bank index, register select and alignment.
    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        sel     = reg_sel_e'(addr[BANK_LSB-1:SEL_LSB]);
        rd_bank = addr[ADDR_W-1:BANK_LSB];
        rd_sel  = sel;
        rd_ok   = aligned && (int'(rd_bank) < NUM_BANKS);
    end

    // Raise one strobe in the addressed bank on an aligned write.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            strb[b] = '0;
            if (wr && aligned && (rd_bank == BIDX_W'(b))) begin
                strb[b].rise_set = (sel == SEL_RISE_SET);
                strb[b].rise_clr = (sel == SEL_RISE_CLR);
                strb[b].fall_set = (sel == SEL_FALL_SET);
                strb[b].fall_clr = (sel == SEL_FALL_CLR);
                strb[b].ack      = (sel == SEL_RAW);
            end
        end
    end

endmodule

// File: rtl/trig_cfg_bank.sv
// Module: trig_cfg_bank
// Holds one bank's rise and fall configuration bits. Each bit is changed only
// by a write-one-to-set or write-one-to-clear strobe.
// Assumes at most one strobe is active per cycle.
module trig_cfg_bank
    import trig_cond_pkg::*;
#(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_wr_t          strb,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] rise_q,
    output logic [BANK_W-1:0] fall_q
);

    logic [BANK_W-1:0] rise_d, fall_d;

    // Apply the set and clear masks to the current configuration.
    always_comb begin
        rise_d = rise_q;
        fall_d = fall_q;
        if (strb.rise_set) rise_d = rise_q | wdata;
        if (strb.rise_clr) rise_d = rise_q & ~wdata;
        if (strb.fall_set) fall_d = fall_q | wdata;
        if (strb.fall_clr) fall_d = fall_q & ~wdata;
    end

    // Configuration registers; reset puts every line in active-high level mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            rise_q <= rise_d;
            fall_q <= fall_d;
        end
    end

    // R2: a set write makes every written-one bit read as 1.
    assert_rise_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strb.rise_set |=> ((rise_q & $past(wdata)) == $past(wdata)));

    // R2: a clear write makes every written-one bit read as 0.
    assert_fall_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strb.fall_clr |=> ((fall_q & $past(wdata)) == '0));

    // R2: without a rise strobe the rise bits hold.
    assert_rise_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(strb.rise_set || strb.rise_clr) |=> $stable(rise_q));

endmodule

// File: rtl/trig_line_cond.sv
// Module: trig_line_cond
// Conditions one bank of lines. Edge-mode lines hold a sticky bit that is set
// on the selected transition and cleared by an acknowledge. Level-mode lines
// pass the input through, inverted for active-low, without latching.
// Assumes irq_in is already synchronous to clk.
module trig_line_cond #(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] irq_in,
    input  logic [BANK_W-1:0] rise_q,
    input  logic [BANK_W-1:0] fall_q,
    input  logic              ack_en,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] irq_out,
    output logic [BANK_W-1:0] raw_view
);

    logic [BANK_W-1:0] prev_q, sticky_q, sticky_d;
    logic [BANK_W-1:0] edge_mode, low_mode, evt, ack_mask;

    // Decode the modes and find this cycle's edge events.
    always_comb begin
        edge_mode = rise_q ^ fall_q;
        low_mode  = rise_q & fall_q;
        evt       = (irq_in & ~prev_q & rise_q & ~fall_q)
                  | (~irq_in & prev_q & fall_q & ~rise_q);
        ack_mask  = ack_en ? wdata : '0;
        sticky_d  = ((sticky_q & ~ack_mask) | evt) & edge_mode;
    end

    // Previous-input register; it tracks in every mode so a mode change makes no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= irq_in;
    end

    // Sticky edge bits; a new edge wins over an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= sticky_d;
    end

    // Select the output and the raw view per line from its mode.
    always_comb begin
        irq_out  = (edge_mode & sticky_q) | (~edge_mode & (irq_in ^ low_mode));
        raw_view = (edge_mode & sticky_q) | (~edge_mode & irq_in);
    end

    // R6/R7: a detected edge is present in the sticky bits on the next cycle.
    assert_edge_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((sticky_q & $past(evt)) == $past(evt)));

    // R8/R9: acknowledged bits without a coincident edge read 0 next cycle.
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_en |=> ((sticky_q & $past(wdata & ~evt)) == '0));

    // R1: every line is clear in the first cycle after reset.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (sticky_q == '0));

endmodule

// File: rtl/irq_trigger_cond.sv
// Module: irq_trigger_cond (top)
// Conditions NUM_BANKS x BANK_W raw interrupts into active-high request lines.
// Each bank has a configuration block and a conditioning block behind a shared
// register decoder and read multiplexer.
// Assumes synchronised inputs and a single-cycle write strobe.
module irq_trigger_cond
    import trig_cond_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 32,
    localparam int LINES    = NUM_BANKS * BANK_W,
    localparam int BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W   = BANK_LSB + BIDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BANK_W-1:0] reg_wdata,
    input  logic              reg_wr,
    output logic [BANK_W-1:0] reg_rdata,
    input  logic [LINES-1:0]  irq_in,
    output logic [LINES-1:0]  irq_out
);

    bank_wr_t [NUM_BANKS-1:0] strb;
    logic [BIDX_W-1:0]        rd_bank;
    reg_sel_e                 rd_sel;
    logic                     rd_ok;

    logic [BANK_W-1:0] rise_b [NUM_BANKS];
    logic [BANK_W-1:0] fall_b [NUM_BANKS];
    logic [BANK_W-1:0] out_b  [NUM_BANKS];
    logic [BANK_W-1:0] raw_b  [NUM_BANKS];

    trig_reg_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .addr    (reg_addr),
        .wr      (reg_wr),
        .strb    (strb),
        .rd_bank (rd_bank),
        .rd_sel  (rd_sel),
        .rd_ok   (rd_ok)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        trig_cfg_bank #(.BANK_W(BANK_W)) u_cfg (
            .clk    (clk),
            .rst_n  (rst_n),
            .strb   (strb[b]),
            .wdata  (reg_wdata),
            .rise_q (rise_b[b]),
            .fall_q (fall_b[b])
        );

        trig_line_cond #(.BANK_W(BANK_W)) u_cond (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_in   (irq_in[b*BANK_W +: BANK_W]),
            .rise_q   (rise_b[b]),
            .fall_q   (fall_b[b]),
            .ack_en   (strb[b].ack),
            .wdata    (reg_wdata),
            .irq_out  (out_b[b]),
            .raw_view (raw_b[b])
        );

        assign irq_out[b*BANK_W +: BANK_W] = out_b[b];
    end

    // Read multiplexer: the addressed bank's register, or 0 when the access is invalid.
    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_ok && (rd_bank == BIDX_W'(b))) begin
                unique case (rd_sel)
                    SEL_STATUS:  reg_rdata = out_b[b];
                    SEL_RAW:     reg_rdata = raw_b[b];
                    SEL_RISE_RD: reg_rdata = rise_b[b];
                    SEL_FALL_RD: reg_rdata = fall_b[b];
                    default:     reg_rdata = '0;
                endcase
            end
        end
    end

    // R3: a write reaches at most one bank.
    logic [NUM_BANKS-1:0] bank_hit;
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) bank_hit[b] = |strb[b];
    end

    assert_one_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_hit));

    // R3: a bank receives a strobe only when a write is present.
    assert_no_spurious_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |-> (bank_hit == '0));

endmodule

// File: tb/tb_irq_trigger_cond.sv
// Testbench for irq_trigger_cond. It sweeps every mode across all 64 lines with
// vector patterns and computes the expected values arithmetically.
module tb_irq_trigger_cond;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic [31:0] rdata;
    logic [63:0] irq_in = '0;
    logic [63:0] irq_out;

    int vec_n = 0;
    int err_n = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_trigger_cond dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_wr    (wr),
        .reg_rdata (rdata),
        .irq_in    (irq_in),
        .irq_out   (irq_out)
    );

    task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
        vec_n++;
        if (act !== exp) begin
            err_n++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec_n++;
        if (act !== exp) begin
            err_n++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One-cycle write issued on a falling edge.
    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // Combinational read, taken between clock edges.
    task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Change the inputs and let one rising edge pass.
    task automatic step_in(input logic [63:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    // Put all lines of both banks into mode m: 0 level high, 1 rising, 2 falling, 3 level low.
    task automatic set_mode_all(input int m);
        for (int b = 0; b < 2; b++) begin
            wr_reg(6'(b*32 + 16 + ((m == 1 || m == 3) ? 0 : 4)), 32'hFFFF_FFFF);
            wr_reg(6'(b*32 + 24 + ((m == 2 || m == 3) ? 0 : 4)), 32'hFFFF_FFFF);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            err_n++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, r2;
        logic [63:0] pats [7];
        logic [63:0] prev, sticky, evt, exp_out, exp_raw;

        pats[0] = 64'h0;
        pats[1] = ~64'h0;
        pats[2] = {32{2'b01}};
        pats[3] = {32{2'b10}};
        pats[4] = (64'h1 << 7) | (64'h1 << 40);
        pats[5] = {16{4'b0011}};
        pats[6] = 64'h0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every register reads 0 after reset.
        for (int a = 0; a < 64; a += 4) begin
            rd_reg(6'(a), r);
            chk32($sformatf("R1 reg %02h after reset", a), r, 32'h0);
        end
        // R1/R4: lines start as active-high level, outputs follow inputs.
        irq_in = 64'hDEAD_BEEF_0123_4567;
        #1;
        chk64("R1 R4 default level passthrough", irq_out, 64'hDEAD_BEEF_0123_4567);
        step_in(64'h0);

        // R2: set/clear per bit; R3: bank mapping.
        wr_reg(6'h10, 32'hA5A5_0F0F);
        rd_reg(6'h08, r);
        chk32("R2 rise set readback", r, 32'hA5A5_0F0F);
        wr_reg(6'h14, 32'h0000_0F00);
        rd_reg(6'h08, r);
        chk32("R2 rise clear only ones", r, 32'hA5A5_000F);
        wr_reg(6'h10, 32'h0);
        rd_reg(6'h08, r);
        chk32("R2 zero write keeps bits", r, 32'hA5A5_000F);
        wr_reg(6'h38, 32'h1234_5678);
        rd_reg(6'h2C, r);
        rd_reg(6'h0C, r2);
        chk32("R3 high bank fall readback", r, 32'h1234_5678);
        chk32("R3 low bank fall untouched", r2, 32'h0);
        wr_reg(6'h3A, 32'hFFFF_FFFF);
        rd_reg(6'h2C, r);
        chk32("R3 misaligned write ignored", r, 32'h1234_5678);
        rd_reg(6'h2D, r);
        chk32("R3 misaligned read is zero", r, 32'h0);
        wr_reg(6'h14, 32'hFFFF_FFFF);
        wr_reg(6'h3C, 32'hFFFF_FFFF);

        // R4-R7, R11: sweep every mode with vector patterns.
        for (int m = 0; m < 4; m++) begin
            step_in(64'h0);
            set_mode_all(m);
            wr_reg(6'h04, 32'hFFFF_FFFF);
            wr_reg(6'h24, 32'hFFFF_FFFF);
            prev = 64'h0;
            sticky = 64'h0;
            for (int k = 0; k < 7; k++) begin
                step_in(pats[k]);
                evt = (m == 1) ? (pats[k] & ~prev) : (m == 2) ? (~pats[k] & prev) : 64'h0;
                sticky |= evt;
                case (m)
                    0: begin exp_out = pats[k];  exp_raw = pats[k]; end
                    3: begin exp_out = ~pats[k]; exp_raw = pats[k]; end
                    default: begin exp_out = sticky; exp_raw = sticky; end
                endcase
                chk64($sformatf("R4 R5 R6 R7 mode %0d pattern %0d", m, k), irq_out, exp_out);
                rd_reg(6'h00, r);
                rd_reg(6'h20, r2);
                chk64($sformatf("R11 status mode %0d pattern %0d", m, k), {r2, r}, exp_out);
                rd_reg(6'h04, r);
                rd_reg(6'h24, r2);
                chk64($sformatf("R11 raw mode %0d pattern %0d", m, k), {r2, r}, exp_raw);
                prev = pats[k];
            end
        end

        // R6/R8: partial acknowledge in rising mode, per bank.
        step_in(64'h0);
        set_mode_all(1);
        wr_reg(6'h04, 32'hFFFF_FFFF);
        wr_reg(6'h24, 32'hFFFF_FFFF);
        step_in(~64'h0);
        step_in(64'h0);
        chk64("R6 sticky survives input fall", irq_out, ~64'h0);
        wr_reg(6'h04, 32'h0000_FFFF);
        chk64("R8 low bank partial ack", irq_out, 64'hFFFF_FFFF_FFFF_0000);
        wr_reg(6'h24, 32'hF0F0_F0F0);
        chk64("R8 high bank partial ack", irq_out, 64'h0F0F_0F0F_FFFF_0000);
        wr_reg(6'h04, 32'hFFFF_FFFF);
        wr_reg(6'h24, 32'hFFFF_FFFF);
        chk64("R8 full ack clears all", irq_out, 64'h0);

        // R9: edge on line 3 in the same cycle as its ack; line 4 is acknowledged cleanly.
        step_in(64'h10);
        chk64("R9 line 4 latched", irq_out, 64'h10);
        @(negedge clk);
        irq_in = 64'h18; addr = 6'h04; wdata = 32'h18; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        chk64("R9 coincident edge kept, line 4 cleared", irq_out, 64'h08);

        // R12: edge to level and back discards the sticky bit.
        wr_reg(6'h14, 32'h8);
        chk64("R12 line 3 now level high", irq_out & 64'h8, 64'h8);
        step_in(64'h0);
        chk64("R12 level follows low input", irq_out, 64'h0);
        wr_reg(6'h10, 32'h8);
        chk64("R12 back to rising, no stale event", irq_out, 64'h0);

        // R10: acknowledge has no effect on level-mode lines.
        step_in(64'h0);
        set_mode_all(0);
        step_in(64'h0F0F_00FF_A5A5_3C3C);
        wr_reg(6'h04, 32'hFFFF_FFFF);
        wr_reg(6'h24, 32'hFFFF_FFFF);
        chk64("R10 level high ignores ack", irq_out, 64'h0F0F_00FF_A5A5_3C3C);
        set_mode_all(3);
        wr_reg(6'h24, 32'hFFFF_FFFF);
        chk64("R10 level low ignores ack", irq_out, ~64'h0F0F_00FF_A5A5_3C3C);
        step_in(64'h0);
        chk64("R10 level low no latching", irq_out, ~64'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
        $finish;
    end

endmodule